// File: doc/BRIEF.md
# Keyed Fractional Clock Divider

This block derives a bit clock from one of several source clocks. Each source is presented as a single-cycle strobe that is synchronous to the fast system clock. The divisor has an integer part and a twelve-bit fractional part. In integer mode every output period spans the integer number of source ticks. In first-order fractional mode an accumulator adds the fractional part once per period, and each carry out of it lengthens the next period by one tick, so the average period approaches DIVI + DIVF/4096.

Software reaches the block through a control word and a divisor word on a single-cycle write port and a combinational read port. A write changes nothing unless its top byte holds the key 0x5A. After enable is cleared, a busy flag keeps the generator running until the current output period has completed. A kill bit stops the generator at once. While busy is set, the divisor, source, mode and invert settings are locked.

Top module: `frac_clk_div`

## Requirements
- R1: A write of either word takes effect only when wr_data[31:24] equals 0x5A. Any other key value leaves both words unchanged.
- R2: The control word holds the source code in bits 3:0, enable in bit 4, kill in bit 5, the read-only busy flag in bit 7, output invert in bit 8 and the mode in bits 10:9. All other bits, including the key byte, read as zero. After reset both words read zero.
- R3: The divisor word holds the fractional part DIVF in bits 11:0 and the integer part DIVI in bits 23:12. Bits 31:24 read as zero.
- R4: In mode 0, and also in modes 2 and 3, every output period lasts DIVI source ticks. The high phase is floor(DIVI/2) ticks and the rest of the period is low. DIVF has no effect in these modes.
- R5: In mode 1 the first period after a start lasts DIVI ticks and leaves DIVF in the accumulator. Each later period adds DIVF to the 12-bit accumulator and lasts DIVI+1 ticks when that addition carries, otherwise DIVI ticks.
- R6: When enable is cleared, busy stays set until the source tick that ends the current period. Busy then falls and the output returns to its idle level. Busy falls only on a source tick or on kill.
- R7: One clock after a keyed write sets kill, busy is clear and the output is at its idle level. No period starts while kill is set.
- R8: Source code 0 (ground) and any code at or above the number of source inputs never start the generator, even with enable set.
- R9: While busy is set, a divisor write is ignored. A control write updates only enable and kill; source, invert and mode keep their values.
- R10: An integer part of 0 or 1 is treated as 2.
- R11: With invert set, clk_out is the complement of the generated clock, so its idle level is high.
- R12: Only strobes on the selected source input advance the generator. Strobes on other inputs have no effect.
- R13: One clock after a keyed write that sets enable with a valid source and kill clear, busy is set and clk_out is at its active level. This starts the high phase of the first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all source strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | One strobe per source; input 0 is the ground source and is never used |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control word, 1 divisor word |
| wr_data | input | 32 | Write data, key byte in bits 31:24 |
| rd_sel | input | 1 | Read target: 0 control word, 1 divisor word |
| rd_data | output | 32 | Combinational read data for the selected word |
| clk_out | output | 1 | Generated bit clock after optional inversion |

## Verification
A write accepted at one clock edge appears in rd_data straight after that edge. Its effect on busy and clk_out shows one edge later, so the bench reads the words at the falling edge after the write edge and samples busy and the clock level at the next falling edge. A source strobe presented before an edge changes the output at that edge, so the bench drives strobes at falling edges and counts them against the level seen at the following falling edge. Each high and low phase is measured in consumed strobes and compared with a period model that the bench builds from DIVI, DIVF and the mode. The end of a disable is checked by reading busy every cycle and, at the first cycle in which it reads low, comparing the strobes counted since the last falling output edge with the expected low phase.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    // Bus word and key
    localparam int          WORD_W  = 32;
    localparam int          KEY_W   = 8;
    localparam int          KEY_LSB = 24;
    localparam logic [7:0]  WR_KEY  = 8'h5A;

    // Word select codes
    localparam logic        SEL_CTRL = 1'b0;
    localparam logic        SEL_DIV  = 1'b1;

    // Control word layout
    localparam int SRC_W    = 4;
    localparam int SRC_LSB  = 0;
    localparam int EN_BIT   = 4;
    localparam int KILL_BIT = 5;
    localparam int BUSY_BIT = 7;
    localparam int INV_BIT  = 8;
    localparam int MODE_W   = 2;
    localparam int MODE_LSB = 9;

    // Divisor word layout
    localparam int DIVF_W   = 12;
    localparam int DIVI_W   = 12;
    localparam int DIVF_LSB = 0;
    localparam int DIVI_LSB = DIVF_LSB + DIVF_W;

    localparam logic [MODE_W-1:0] MODE_FRAC1 = 2'd1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              inv;
        logic              kill;
        logic              en;
        logic [SRC_W-1:0]  src;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIVI_W-1:0] divi;
        logic [DIVF_W-1:0] divf;
    } regs_t;

endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic              busy,
    output logic [WORD_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output logic [DIVI_W-1:0] divi,
    output logic [DIVF_W-1:0] divf
);

    regs_t regs_d, regs_q;
    logic  key_ok;

    always_comb begin
        regs_d = regs_q;
        key_ok = (wr_data[KEY_LSB +: KEY_W] == WR_KEY);
        if (wr_en && key_ok) begin
            if (wr_sel == SEL_CTRL) begin
                // enable and kill are always writable
                regs_d.ctrl.en   = wr_data[EN_BIT];
                regs_d.ctrl.kill = wr_data[KILL_BIT];
                if (!busy) begin
                    regs_d.ctrl.src  = wr_data[SRC_LSB +: SRC_W];
                    regs_d.ctrl.inv  = wr_data[INV_BIT];
                    regs_d.ctrl.mode = wr_data[MODE_LSB +: MODE_W];
                end
            end else if (!busy) begin
                regs_d.divi = wr_data[DIVI_LSB +: DIVI_W];
                regs_d.divf = wr_data[DIVF_LSB +: DIVF_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_CTRL) begin
            rd_data[SRC_LSB +: SRC_W]   = regs_q.ctrl.src;
            rd_data[EN_BIT]             = regs_q.ctrl.en;
            rd_data[KILL_BIT]           = regs_q.ctrl.kill;
            rd_data[BUSY_BIT]           = busy;
            rd_data[INV_BIT]            = regs_q.ctrl.inv;
            rd_data[MODE_LSB +: MODE_W] = regs_q.ctrl.mode;
        end else begin
            rd_data[DIVF_LSB +: DIVF_W] = regs_q.divf;
            rd_data[DIVI_LSB +: DIVI_W] = regs_q.divi;
        end
    end

    assign ctrl = regs_q.ctrl;
    assign divi = regs_q.divi;
    assign divf = regs_q.divf;

    // R1: a write without the key leaves both words untouched
    assert_key_guard_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> $stable(regs_q));

    // R9: the divisor cannot change while the generator is busy
    assert_div_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(regs_q.divi) && $stable(regs_q.divf)));

    // R9: source, invert and mode are locked while busy
    assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(regs_q.ctrl.src) && $stable(regs_q.ctrl.mode)
                  && $stable(regs_q.ctrl.inv)));

endmodule

// File: rtl/fcd_src_sel.sv
module fcd_src_sel #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick,
    output logic               src_ok
);

    logic [NUM_SRC-1:0] match;

    // code 0 is the ground source: it never matches
    assign match[0] = 1'b0;

    for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
        assign match[i] = (sel == SEL_W'(i));
    end

    assign src_ok = |match;
    assign tick   = |(match & src_tick);

endmodule

// File: rtl/fcd_core.sv
module fcd_core #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              src_ok,
    input  logic              en,
    input  logic              kill,
    input  logic              frac_mode,
    input  logic [INT_W-1:0]  divi,
    input  logic [FRAC_W-1:0] divf,
    output logic              busy,
    output logic              raw
);

    localparam int LEN_W = INT_W + 1;

    typedef struct packed {
        logic              busy;
        logic              raw;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [FRAC_W-1:0] acc;
    } core_t;

    core_t             core_d, core_q;
    logic [LEN_W-1:0]  divi_eff;
    logic [FRAC_W-1:0] frac_in;
    logic [FRAC_W:0]   acc_sum;
    logic [LEN_W-1:0]  cnt_inc;
    logic              last_tick;

    always_comb begin
        divi_eff  = (divi < INT_W'(2)) ? LEN_W'(2) : LEN_W'(divi);
        frac_in   = frac_mode ? divf : '0;
        acc_sum   = {1'b0, core_q.acc} + {1'b0, frac_in};
        cnt_inc   = core_q.cnt + LEN_W'(1);
        last_tick = (core_q.cnt == core_q.len - LEN_W'(1));

        core_d = core_q;
        if (kill) begin
            core_d = '0;
        end else if (!core_q.busy) begin
            if (en && src_ok) begin
                core_d.busy = 1'b1;
                core_d.raw  = 1'b1;
                core_d.cnt  = '0;
                core_d.len  = divi_eff;
                core_d.acc  = frac_in;
            end
        end else if (tick) begin
            if (last_tick) begin
                if (en) begin
                    core_d.len = divi_eff + LEN_W'(acc_sum[FRAC_W]);
                    core_d.acc = acc_sum[FRAC_W-1:0];
                    core_d.cnt = '0;
                    core_d.raw = 1'b1;
                end else begin
                    core_d = '0;
                end
            end else begin
                core_d.cnt = cnt_inc;
                core_d.raw = (cnt_inc < (core_q.len >> 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign busy = core_q.busy;
    assign raw  = core_q.raw;

    // R6: busy only drops on a source tick or a kill
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.busy && !kill && !tick) |=> core_q.busy);

    // R6: an idle generator holds its clock low
    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_q.busy |-> !core_q.raw);

    // R7: kill stops the generator on the next edge
    assert_kill_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!core_q.busy && !core_q.raw));

    // R10: a running period is never shorter than two ticks
    assert_len_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.busy |-> (core_q.len >= LEN_W'(2)));

    // R4: the tick counter stays inside the current period
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.busy |-> (core_q.cnt < core_q.len));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [31:0]        wr_data,
    input  logic               rd_sel,
    output logic [31:0]        rd_data,
    output logic               clk_out
);

    ctrl_t             ctrl;
    logic [DIVI_W-1:0] divi;
    logic [DIVF_W-1:0] divf;
    logic              busy;
    logic              raw;
    logic              tick;
    logic              src_ok;

    fcd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .busy    (busy),
        .rd_data (rd_data),
        .ctrl    (ctrl),
        .divi    (divi),
        .divf    (divf)
    );

    fcd_src_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SRC_W)
    ) u_sel (
        .src_tick (src_tick),
        .sel      (ctrl.src),
        .tick     (tick),
        .src_ok   (src_ok)
    );

    fcd_core #(
        .INT_W  (DIVI_W),
        .FRAC_W (DIVF_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .src_ok    (src_ok),
        .en        (ctrl.en),
        .kill      (ctrl.kill),
        .frac_mode (ctrl.mode == MODE_FRAC1),
        .divi      (divi),
        .divf      (divf),
        .busy      (busy),
        .raw       (raw)
    );

    assign clk_out = raw ^ ctrl.inv;

    // R8: without a valid source an idle generator stays idle
    assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !src_ok) |=> !busy);

endmodule

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        clk_out;

    frac_clk_div #(.NUM_SRC(8)) u_frac_clk_div (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .clk_out(clk_out)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // monitor state
    int sel_exp = 0;
    bit inv_exp = 1'b0;
    bit tick_en = 1'b0;
    int den = 2;
    int hi_arr[64];
    int lo_arr[64];
    int n_hi = 0, n_lo = 0, since = 0, since_snap = 0;
    bit seen = 1'b0, prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [31:0] mk_ctrl(input int mode, input bit inv, input bit kill,
                                             input bit en, input int src);
        logic [31:0] w;
        w = '0;
        w[31:24] = 8'h5A;
        w[10:9]  = mode[1:0];
        w[8]     = inv;
        w[5]     = kill;
        w[4]     = en;
        w[3:0]   = src[3:0];
        return w;
    endfunction

    function automatic logic [31:0] mk_div(input int divi, input int divf);
        return {8'h5A, divi[11:0], divf[11:0]};
    endfunction

    task automatic wr(input bit s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit s, output logic [31:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    // strobe driver and phase measurement
    always @(negedge clk) begin
        bit o, t;
        logic [7:0] nz;
        if (rst_n) begin
            o = clk_out ^ inv_exp;
            since_snap = since;
            if (o != prev) begin
                if (o) begin
                    if (seen && n_lo < 64) begin lo_arr[n_lo] = since; n_lo++; end
                    seen = 1'b1;
                end else if (n_hi < 64) begin
                    hi_arr[n_hi] = since; n_hi++;
                end
                since = 0;
            end
            prev = o;
            t  = tick_en && (($urandom % den) == 0);
            nz = 8'($urandom);
            if (sel_exp >= 1 && sel_exp < 8) begin
                nz[sel_exp] = t;
                if (t) since++;
            end
            src_tick = nz;
        end
    end

    task automatic mon_clear();
        @(posedge clk);
        #1;
        n_hi = 0; n_lo = 0; since = 0; seen = 1'b0;
        prev = clk_out ^ inv_exp;
    endtask

    task automatic prepare(input int src, input int divi, input int divf, input int mode, input bit inv);
        wr(1'b1, mk_div(divi, divf));
        wr(1'b0, mk_ctrl(mode, inv, 1'b0, 1'b0, src));
        sel_exp = src; inv_exp = inv;
        mon_clear();
    endtask

    task automatic wait_periods(input int n, input string req);
        int w = 0;
        while ((n_hi < n || n_lo < n - 1) && w < 20000) begin
            @(negedge clk); w++;
        end
        chk(w < 20000, req, n_hi, n);
    endtask

    task automatic stop_gen(input int src, input int mode, input bit inv);
        logic [31:0] v;
        int w = 0;
        wr(1'b0, mk_ctrl(mode, inv, 1'b0, 1'b0, src));
        do begin
            @(negedge clk); rd(1'b0, v); w++;
        end while (v[7] && w < 5000);
    endtask

    task automatic run_cfg(input int src, input int divi, input int divf, input int mode,
                           input bit inv, input int dn, input int n, input string req);
        int de, fe, acc, l;
        den = dn; tick_en = 1'b1;
        prepare(src, divi, divf, mode, inv);
        wr(1'b0, mk_ctrl(mode, inv, 1'b0, 1'b1, src));
        wait_periods(n, req);
        de  = (divi < 2) ? 2 : divi;
        fe  = (mode == 1) ? divf : 0;
        acc = fe;
        for (int k = 0; k < n; k++) begin
            if (k == 0) l = de;
            else begin
                acc = acc + fe;
                l   = de + ((acc >= 4096) ? 1 : 0);
                acc = acc & 4095;
            end
            chk(hi_arr[k] == l / 2, {req, " high phase"}, hi_arr[k], l / 2);
            if (k < n - 1)
                chk(lo_arr[k] == l - l / 2, {req, " low phase"}, lo_arr[k], l - l / 2);
        end
        stop_gen(src, mode, inv);
    endtask

    initial begin
        logic [31:0] v, e;
        int w;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(1'b0, v); chk(v == 0, "R2 reset control word", v, 0);
        rd(1'b1, v); chk(v == 0, "R3 reset divisor word", v, 0);
        chk(clk_out == 1'b0, "R11 idle level after reset", clk_out, 0);

        // field layout readback
        wr(1'b1, mk_div(37, 12'h9AB));
        rd(1'b1, v); chk(v == {8'h00, 12'd37, 12'h9AB}, "R3 divisor fields", v, {8'h00, 12'd37, 12'h9AB});
        wr(1'b0, mk_ctrl(1, 1'b1, 1'b0, 1'b0, 3));
        e = mk_ctrl(1, 1'b1, 1'b0, 1'b0, 3) & 32'h00FF_FFFF;
        rd(1'b0, v); chk(v == e, "R2 control fields", v, e);
        chk(clk_out == 1'b1, "R11 inverted idle level", clk_out, 1);

        // unkeyed writes are ignored
        v = mk_ctrl(0, 1'b0, 1'b0, 1'b1, 2); v[31:24] = 8'hA5;
        wr(1'b0, v);
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk(v == e, "R1 unkeyed control write ignored", v, e);
        v = mk_div(5, 7); v[31:24] = 8'h00;
        wr(1'b1, v);
        rd(1'b1, v); chk(v == {8'h00, 12'd37, 12'h9AB}, "R1 unkeyed divisor write ignored", v, {8'h00, 12'd37, 12'h9AB});

        // start timing and busy lock
        den = 2; tick_en = 1'b1;
        prepare(2, 6, 0, 0, 1'b0);
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b1, 2));
        rd(1'b0, v); chk(v[7] == 1'b0, "R13 busy not yet set", v[7], 0);
        @(negedge clk);
        rd(1'b0, v); chk(v[7] == 1'b1, "R13 busy set one clock later", v[7], 1);
        chk(clk_out == 1'b1, "R13 output starts high", clk_out, 1);
        wr(1'b1, mk_div(3, 5));
        rd(1'b1, v); chk(v == {8'h00, 12'd6, 12'd0}, "R9 divisor locked while busy", v, {8'h00, 12'd6, 12'd0});
        wr(1'b0, mk_ctrl(1, 1'b1, 1'b0, 1'b1, 5));
        e = (mk_ctrl(0, 1'b0, 1'b0, 1'b1, 2) & 32'h00FF_FFFF) | 32'h80;
        rd(1'b0, v); chk(v == e, "R9 control fields locked while busy", v, e);
        stop_gen(2, 0, 1'b0);

        // directed period checks (noise on the other inputs covers R12)
        run_cfg(1, 5, 0, 0, 1'b0, 1, 6, "R4 odd divisor R12");
        run_cfg(3, 6, 12'h800, 0, 1'b0, 2, 6, "R4 fraction ignored in mode 0");
        run_cfg(5, 7, 12'h555, 2, 1'b0, 2, 6, "R4 mode 2 divides by integer");
        run_cfg(4, 3, 12'h400, 1, 1'b0, 2, 10, "R5 quarter fraction");
        run_cfg(6, 0, 0, 0, 1'b0, 1, 6, "R10 zero divisor");
        run_cfg(7, 1, 12'hC00, 1, 1'b0, 3, 10, "R10 R5 unit divisor with fraction");
        run_cfg(2, 4, 0, 0, 1'b1, 2, 6, "R11 inverted output");

        // random configurations
        for (int r = 0; r < 6; r++) begin
            run_cfg(1 + int'($urandom % 7), int'($urandom % 10), int'($urandom % 4096),
                    int'($urandom % 4), 1'($urandom % 2), 1 + int'($urandom % 3), 12,
                    "R5 R12 random config");
        end

        // clean disable
        den = 1; tick_en = 1'b1;
        prepare(3, 8, 0, 0, 1'b0);
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b1, 3));
        wait_periods(2, "R6 warm-up");
        tick_en = 1'b0;
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b0, 3));
        repeat (10) @(negedge clk);
        rd(1'b0, v); chk(v[7] == 1'b1, "R6 busy held after disable", v[7], 1);
        tick_en = 1'b1;
        w = 0;
        do begin
            @(negedge clk); rd(1'b0, v); w++;
        end while (v[7] && w < 2000);
        chk(v[7] == 1'b0, "R6 busy falls", v[7], 0);
        chk(clk_out == 1'b0, "R6 output low after stop", clk_out, 0);
        chk(since_snap == 4, "R6 last low phase complete", since_snap, 4);

        // kill
        den = 1; tick_en = 1'b1;
        prepare(1, 10, 0, 0, 1'b1);
        wr(1'b0, mk_ctrl(0, 1'b1, 1'b0, 1'b1, 1));
        wait_periods(1, "R7 warm-up");
        tick_en = 1'b0;
        wr(1'b0, mk_ctrl(0, 1'b1, 1'b1, 1'b1, 1));
        @(negedge clk);
        rd(1'b0, v); chk(v[7] == 1'b0, "R7 busy clear one clock after kill", v[7], 0);
        chk(clk_out == 1'b1, "R7 output at idle level after kill", clk_out, 1);
        tick_en = 1'b1;
        repeat (40) @(negedge clk);
        rd(1'b0, v); chk(v[7] == 1'b0, "R7 no start while kill set", v[7], 0);
        chk(clk_out == 1'b1, "R7 output held idle", clk_out, 1);
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b0, 1));

        // ground and out-of-range sources
        inv_exp = 1'b0; sel_exp = 0; tick_en = 1'b1; den = 1;
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b1, 0));
        repeat (30) @(negedge clk);
        rd(1'b0, v); chk(v[7] == 1'b0, "R8 ground source never starts", v[7], 0);
        chk(clk_out == 1'b0, "R8 ground source output", clk_out, 0);
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b0, 0));
        sel_exp = 9;
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b1, 9));
        repeat (30) @(negedge clk);
        rd(1'b0, v); chk(v[7] == 1'b0, "R8 unused source code never starts", v[7], 0);
        chk(clk_out == 1'b0, "R8 unused source output", clk_out, 0);
        wr(1'b0, mk_ctrl(0, 1'b0, 1'b0, 1'b0, 0));

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule